// File: doc/BRIEF.md
# Page-Crossing Multiword Access Splitter

This block stands between a load/store unit and two shared resources: an address translator and a memory whose words are 16 bits wide. A request names a virtual address, an operand size of one, two or four words, and a direction. The block asks the translator for the first word's physical address and looks at that address's offset within its 1024-word page. If the whole operand fits before the page ends, the remaining words are reached by counting up from that one physical address. If the operand would run past the end of the page, every later word gets its own translation of the virtual address plus its index.

Loads are assembled and stores are scattered so that the word at the lowest address is the most significant part of the operand. Translations are requested with the direction of the access, so the translator can mark pages as modified on stores. A fault reported by any translation ends the access at once. Only one access is in flight; a pulse on `done` ends each one.

Top module: `xword_split`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `xl_req` and `mem_en` are all low.
- R2: A size code of 0 (or the spare code 3) moves one word with exactly one translation; load data appears in `rdata[15:0]` with the upper bits zero.
- R3: A size code of 1 (two words) whose first physical in-page offset (`paddr[9:0]`) is at most 1022 uses one translation, and its second word is at the first physical address plus one.
- R4: A two-word access whose first in-page offset is 1023 uses two translations, and the second word goes to the translation of the virtual address plus one.
- R5: A size code of 2 (four words) uses one translation when the first in-page offset is at most 1020, and four translations (of the virtual address plus 0, 1, 2, 3) when the offset is 1021 to 1023.
- R6: The word at the lowest address holds the operand's most significant 16 bits; load results are right-justified in `rdata` and store data is taken from the low bits of `req_wdata` in the same way.
- R7: Every translation request carries `xl_write` equal to the access direction (1 for a store, 0 for a load) and holds its address and direction until acknowledged.
- R8: A translation answered with `xl_fault` high ends the access: `done` and `fault` rise together in the cycle after, no further memory access takes place, and a store keeps only the words written before the fault.
- R9: A request presented while `busy` is high is ignored; it causes no translation, no memory access and no change to the running access's result.
- R10: `done` is high for exactly one cycle per access, and `rdata` keeps the loaded value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0: one word, 1: two words, 2: four words, 3: one word |
| req_vaddr | input | VA_W | Virtual word address of the operand |
| req_wdata | input | 64 | Store operand, right-justified |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle end-of-access strobe |
| fault | output | 1 | With `done`: the access was aborted by a translation fault |
| rdata | output | 64 | Assembled load operand, right-justified |
| xl_req | output | 1 | Translation request, held until acknowledged |
| xl_vaddr | output | VA_W | Virtual address to translate |
| xl_write | output | 1 | Access type for the translation (1 = write) |
| xl_ack | input | 1 | Translation result valid |
| xl_fault | input | 1 | With `xl_ack`: translation failed |
| xl_paddr | input | PA_W | With `xl_ack`: physical word address |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PA_W | Physical word address |
| mem_wdata | output | 16 | Word to store |
| mem_rdata | input | 16 | Loaded word, valid the cycle after a read strobe |

## Verification
On every cycle the assertions check that a faulting translation is followed by the end strobe with no memory access, that `done` never lasts two cycles, that an idle block with no request stays idle, that a pending translation request keeps its address and direction, and that an access using a single translation never addresses a word outside that translation's page. Which offsets lead to one translation or several, where each word of a split operand lands, the big-word ordering of data, the partial store left by a fault and the rejection of requests made while busy are shown only by the bench's directed scenarios, which count translations and memory writes against a page-table model.

// File: rtl/xws_pkg.sv
package xws_pkg;

    localparam int WORD_W    = 16;
    localparam int MAX_WORDS = 4;
    localparam int IDX_W     = $clog2(MAX_WORDS);
    localparam int OPER_W    = WORD_W * MAX_WORDS;

    typedef enum logic [1:0] {
        SZ_ONE  = 2'd0,
        SZ_TWO  = 2'd1,
        SZ_FOUR = 2'd2,
        SZ_SPARE = 2'd3
    } opsize_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_XLATE,
        PH_ACCESS,
        PH_CAPTURE,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        logic             write;
        logic [IDX_W-1:0] last;
    } job_t;

    // Index of the final word of an operand of the given size.
    function automatic logic [IDX_W-1:0] last_index(input opsize_e sz);
        case (sz)
            SZ_TWO:  last_index = IDX_W'(1);
            SZ_FOUR: last_index = IDX_W'(3);
            default: last_index = '0;
        endcase
    endfunction

    // True when the operand starting at in-page offset 'off' runs past the page end.
    function automatic logic spills(input int unsigned off, input int unsigned last,
                                    input int unsigned page_words);
        spills = (off + last) >= page_words;
    endfunction

endpackage

// File: rtl/xws_seq.sv
module xws_seq
    import xws_pkg::*;
#(
    parameter int PG_BITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic             xl_ack,
    input  logic             xl_fault,
    input  logic [PG_BITS-1:0] xl_off,
    output logic             busy,
    output logic             accept,
    output logic             xl_req,
    output logic             xl_write,
    output logic             ld_pa,
    output logic             mem_en,
    output logic             mem_we,
    output logic             cap,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] last,
    output logic             split,
    output logic             done,
    output logic             fault
);

    localparam int unsigned PAGE_WORDS = 1 << PG_BITS;

    phase_e st;
    job_t   job;
    logic   flt;

    assign busy     = (st != PH_IDLE);
    assign accept   = (st == PH_IDLE) && req_valid;
    assign xl_req   = (st == PH_XLATE);
    assign xl_write = job.write;
    assign ld_pa    = (st == PH_XLATE) && xl_ack && !xl_fault;
    assign mem_en   = (st == PH_ACCESS);
    assign mem_we   = (st == PH_ACCESS) && job.write;
    assign cap      = (st == PH_CAPTURE);
    assign last     = job.last;
    assign done     = (st == PH_FINISH);
    assign fault    = (st == PH_FINISH) && flt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PH_IDLE;
            job   <= '0;
            idx   <= '0;
            split <= 1'b0;
            flt   <= 1'b0;
        end else begin
            case (st)
                PH_IDLE: begin
                    if (req_valid) begin
                        job.write <= req_write;
                        job.last  <= last_index(opsize_e'(req_size));
                        idx       <= '0;
                        split     <= 1'b0;
                        flt       <= 1'b0;
                        st        <= PH_XLATE;
                    end
                end
                PH_XLATE: begin
                    if (xl_ack) begin
                        if (xl_fault) begin
                            flt <= 1'b1;
                            st  <= PH_FINISH;
                        end else begin
                            if (idx == '0)
                                split <= spills(32'(xl_off), 32'(job.last), PAGE_WORDS);
                            st <= PH_ACCESS;
                        end
                    end
                end
                PH_ACCESS: begin
                    if (!job.write) begin
                        st <= PH_CAPTURE;
                    end else if (idx == job.last) begin
                        st <= PH_FINISH;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= split ? PH_XLATE : PH_ACCESS;
                    end
                end
                PH_CAPTURE: begin
                    if (idx == job.last) begin
                        st <= PH_FINISH;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= split ? PH_XLATE : PH_ACCESS;
                    end
                end
                PH_FINISH: st <= PH_IDLE;
                default:   st <= PH_IDLE;
            endcase
        end
    end

    // R8: a faulting translation ends the access with no memory access.
    a_r8_abort_on_fault: assert property (@(posedge clk) disable iff (rst)
        (xl_req && xl_ack && xl_fault) |=> (done && fault && !mem_en));

    // R10: the end strobe lasts a single cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: without a request an idle block stays idle.
    a_r9_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !busy);

endmodule

// File: rtl/xws_addr.sv
module xws_addr
    import xws_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 22,
    parameter int PG_BITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             ld_pa,
    input  logic [PA_W-1:0]  xl_paddr,
    input  logic [IDX_W-1:0] idx,
    input  logic             split,
    input  logic             mem_en,
    output logic [VA_W-1:0]  xl_vaddr,
    output logic [PA_W-1:0]  mem_addr
);

    logic [VA_W-1:0] vbase;
    logic [PA_W-1:0] pa_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            vbase  <= '0;
            pa_cur <= '0;
        end else begin
            if (accept) vbase  <= req_vaddr;
            if (ld_pa)  pa_cur <= xl_paddr;
        end
    end

    // Each later word of a split operand is translated at its own virtual address.
    assign xl_vaddr = vbase + VA_W'(idx);
    // Split: last translation is the word's address; otherwise count from word 0.
    assign mem_addr = split ? pa_cur : (pa_cur + PA_W'(idx));

    // R3: a single-translation access never leaves the translated page.
    a_r3_one_page: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !split) |-> (mem_addr[PA_W-1:PG_BITS] == pa_cur[PA_W-1:PG_BITS]));

endmodule

// File: rtl/xws_data.sv
module xws_data
    import xws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [OPER_W-1:0] req_wdata,
    input  logic [IDX_W-1:0]  last,
    input  logic [IDX_W-1:0]  idx,
    input  logic              cap,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [OPER_W-1:0] rdata
);

    logic [WORD_W-1:0] wbuf [MAX_WORDS];
    logic [WORD_W-1:0] rbuf [MAX_WORDS];
    logic [IDX_W-1:0]  slot;

    // Word 0 (lowest address) sits in the most significant used slot.
    assign slot = last - idx;

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                wbuf[g] <= '0;
                rbuf[g] <= '0;
            end else if (accept) begin
                wbuf[g] <= req_wdata[g*WORD_W +: WORD_W];
                rbuf[g] <= '0;
            end else if (cap && (slot == IDX_W'(g))) begin
                rbuf[g] <= mem_rdata;
            end
        end
        assign rdata[g*WORD_W +: WORD_W] = rbuf[g];
    end

    always_comb begin
        mem_wdata = '0;
        for (int k = 0; k < MAX_WORDS; k++) begin
            if (slot == IDX_W'(k)) mem_wdata = wbuf[k];
        end
    end

endmodule

// File: rtl/xword_split.sv
module xword_split
    import xws_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 22,
    parameter int PG_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [63:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [63:0]       rdata,
    output logic              xl_req,
    output logic [VA_W-1:0]   xl_vaddr,
    output logic              xl_write,
    input  logic              xl_ack,
    input  logic              xl_fault,
    input  logic [PA_W-1:0]   xl_paddr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);

    logic             accept;
    logic             ld_pa;
    logic             cap;
    logic             split;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last;

    xws_seq #(.PG_BITS(PG_BITS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_size (req_size),
        .xl_ack   (xl_ack),
        .xl_fault (xl_fault),
        .xl_off   (xl_paddr[PG_BITS-1:0]),
        .busy     (busy),
        .accept   (accept),
        .xl_req   (xl_req),
        .xl_write (xl_write),
        .ld_pa    (ld_pa),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .cap      (cap),
        .idx      (idx),
        .last     (last),
        .split    (split),
        .done     (done),
        .fault    (fault)
    );

    xws_addr #(.VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_vaddr(req_vaddr),
        .ld_pa    (ld_pa),
        .xl_paddr (xl_paddr),
        .idx      (idx),
        .split    (split),
        .mem_en   (mem_en),
        .xl_vaddr (xl_vaddr),
        .mem_addr (mem_addr)
    );

    xws_data u_data (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_wdata(req_wdata),
        .last     (last),
        .idx      (idx),
        .cap      (cap),
        .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata),
        .rdata    (rdata)
    );

    // R7: a pending translation keeps its address and direction.
    a_r7_xl_hold: assert property (@(posedge clk) disable iff (rst)
        (xl_req && !xl_ack) |=> (xl_req && $stable(xl_vaddr) && $stable(xl_write)));

endmodule

// File: tb/sim_xword_split.sv
module sim_xword_split;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_vaddr = '0;
    logic [63:0] req_wdata = '0;
    logic        busy, done, fault;
    logic [63:0] rdata;
    logic        xl_req, xl_write;
    logic [31:0] xl_vaddr;
    logic        xl_ack = 1'b0;
    logic        xl_fault = 1'b0;
    logic [21:0] xl_paddr = '0;
    logic        mem_en, mem_we;
    logic [21:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int n_xl = 0, n_badtype = 0, n_wr = 0, n_rd = 0;
    logic        exp_write = 1'b0;
    logic        fault_en = 1'b0;
    logic [11:0] fault_page = '0;
    logic [15:0] mem_store [logic [21:0]];

    logic [63:0] got_rdata;
    logic        got_fault;
    int          d_xl, d_wr, d_rd, d_bad;

    always #5 clk = ~clk;

    xword_split u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .fault(fault), .rdata(rdata),
        .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_write(xl_write),
        .xl_ack(xl_ack), .xl_fault(xl_fault), .xl_paddr(xl_paddr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [21:0] xlate(input logic [31:0] v);
        logic [11:0] pp;
        pp = v[21:10] * 12'd5 + 12'd1;
        return {pp, v[9:0]};
    endfunction

    function automatic logic [15:0] memrd(input logic [21:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Translator model: answers one cycle after a request.
    always @(posedge clk) begin
        if (rst) begin
            xl_ack <= 1'b0;
        end else if (xl_req && !xl_ack) begin
            xl_ack   <= 1'b1;
            xl_paddr <= xlate(xl_vaddr);
            xl_fault <= fault_en && (xl_vaddr[21:10] == fault_page);
            n_xl     <= n_xl + 1;
            if (xl_write !== exp_write) n_badtype <= n_badtype + 1;
        end else begin
            xl_ack <= 1'b0;
        end
    end

    // Memory model: read data one cycle after the strobe.
    always @(posedge clk) begin
        if (!rst && mem_en) begin
            if (mem_we) begin
                mem_store[mem_addr] = mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= memrd(mem_addr);
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1) begin
            @(negedge clk);
            n++;
            if (n > 500) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual no done expected done");
                break;
            end
        end
    endtask

    task automatic run(input logic wr, input logic [1:0] sz, input logic [31:0] va,
                       input logic [63:0] wd);
        int x0, w0, r0, b0;
        @(negedge clk);
        x0 = n_xl; w0 = n_wr; r0 = n_rd; b0 = n_badtype;
        exp_write = wr;
        req_write = wr; req_size = sz; req_vaddr = va; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        got_rdata = rdata;
        got_fault = fault;
        @(negedge clk);
        d_xl = n_xl - x0; d_wr = n_wr - w0; d_rd = n_rd - r0; d_bad = n_badtype - b0;
    endtask

    function automatic logic [15:0] expw(input logic [31:0] va, input int i, input logic sp);
        if (sp) return memrd(xlate(va + 32'(i)));
        return memrd(xlate(va) + 22'(i));
    endfunction

    task automatic t_reset();
        chk({59'd0, busy, done, fault, xl_req, mem_en}, 64'd0, "R1 reset outputs");
    endtask

    task automatic t_one_word();
        logic [31:0] va = 32'h0000_1405;
        logic [63:0] e;
        e = {48'd0, expw(va, 0, 1'b0)};
        run(1'b0, 2'd0, va, '0);
        chk(d_xl, 1, "R2 one-word translations");
        chk(got_rdata, e, "R2 R6 one-word data");
        va = 32'h0000_27FF;
        e = {48'd0, expw(va, 0, 1'b0)};
        run(1'b0, 2'd3, va, '0);
        chk(d_xl, 1, "R2 spare size translations");
        chk(got_rdata, e, "R2 spare size data");
        chk(d_bad, 0, "R7 load direction");
    endtask

    task automatic t_two_words();
        logic [31:0] va = 32'h0000_0BFE;
        logic [63:0] e;
        e = {32'd0, expw(va, 0, 1'b0), expw(va, 1, 1'b0)};
        run(1'b0, 2'd1, va, '0);
        chk(d_xl, 1, "R3 in-page two-word translations");
        chk(got_rdata, e, "R3 R6 in-page two-word data");
        va = 32'h0000_0BFF;
        e = {32'd0, expw(va, 0, 1'b1), expw(va, 1, 1'b1)};
        run(1'b0, 2'd1, va, '0);
        chk(d_xl, 2, "R4 crossing two-word translations");
        chk(got_rdata, e, "R4 crossing two-word data");
    endtask

    task automatic t_four_words();
        logic [31:0] va = 32'h0000_33FC;
        logic [63:0] e;
        e = {expw(va, 0, 1'b0), expw(va, 1, 1'b0), expw(va, 2, 1'b0), expw(va, 3, 1'b0)};
        run(1'b0, 2'd2, va, '0);
        chk(d_xl, 1, "R5 four-word offset 1020 translations");
        chk(got_rdata, e, "R5 four-word offset 1020 data");
        va = 32'h0000_33FD;
        e = {expw(va, 0, 1'b1), expw(va, 1, 1'b1), expw(va, 2, 1'b1), expw(va, 3, 1'b1)};
        run(1'b0, 2'd2, va, '0);
        chk(d_xl, 4, "R5 four-word offset 1021 translations");
        chk(got_rdata, e, "R5 four-word offset 1021 data");
        va = 32'h0000_33FF;
        e = {expw(va, 0, 1'b1), expw(va, 1, 1'b1), expw(va, 2, 1'b1), expw(va, 3, 1'b1)};
        run(1'b0, 2'd2, va, '0);
        chk(d_xl, 4, "R5 four-word offset 1023 translations");
        chk(got_rdata, e, "R5 four-word offset 1023 data");
    endtask

    task automatic t_stores();
        logic [31:0] va = 32'h0000_4BFE;
        logic [63:0] wd = 64'h1111_2222_3333_4444;
        run(1'b1, 2'd2, va, wd);
        chk(d_xl, 4, "R5 split store translations");
        chk(d_wr, 4, "R5 split store writes");
        chk(d_bad, 0, "R7 store direction");
        chk({memrd(xlate(va)), memrd(xlate(va + 1)), memrd(xlate(va + 2)), memrd(xlate(va + 3))},
            wd, "R6 split store word order");
        run(1'b0, 2'd2, va, '0);
        chk(got_rdata, wd, "R6 split store read back");
        va = 32'h0000_5010;
        run(1'b1, 2'd1, va, 64'h0000_0000_ABCD_1234);
        chk(d_xl, 1, "R3 in-page store translations");
        chk({memrd(xlate(va)), memrd(xlate(va) + 22'd1)}, 32'hABCD_1234, "R3 R6 in-page store words");
    endtask

    task automatic t_fault();
        logic [31:0] va = 32'h0000_5BFF;
        logic [15:0] before1;
        before1 = memrd(xlate(va + 1));
        fault_page = 12'h017;
        fault_en = 1'b1;
        run(1'b1, 2'd1, va, 64'h0000_0000_7777_8888);
        chk(got_fault, 1'b1, "R8 store fault flagged");
        chk(d_xl, 2, "R8 store fault translations");
        chk(d_wr, 1, "R8 store fault writes");
        chk(memrd(xlate(va)), 16'h7777, "R8 word before fault written");
        chk(memrd(xlate(va + 1)), before1, "R8 faulting word untouched");
        run(1'b0, 2'd0, 32'h0000_5C20, '0);
        chk(got_fault, 1'b1, "R8 load fault flagged");
        chk(d_rd, 0, "R8 load fault no memory read");
        fault_en = 1'b0;
        run(1'b0, 2'd0, 32'h0000_5C20, '0);
        chk(got_fault, 1'b0, "R8 fault clears on next access");
    endtask

    task automatic t_busy();
        logic [31:0] va = 32'h0000_63FE;
        logic [63:0] e;
        int x0, w0;
        e = {expw(va, 0, 1'b1), expw(va, 1, 1'b1), expw(va, 2, 1'b1), expw(va, 3, 1'b1)};
        @(negedge clk);
        x0 = n_xl; w0 = n_wr;
        exp_write = 1'b0;
        req_write = 1'b0; req_size = 2'd2; req_vaddr = va; req_wdata = '0;
        req_valid = 1'b1;
        @(negedge clk);
        req_write = 1'b1; req_size = 2'd0; req_vaddr = 32'h0000_7000; req_wdata = 64'hFFFF;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk(rdata, e, "R9 running access result unchanged");
        chk(fault, 1'b0, "R9 no fault");
        @(negedge clk);
        chk(done, 1'b0, "R10 done lasts one cycle");
        repeat (8) @(negedge clk);
        chk(n_xl - x0, 4, "R9 no extra translation");
        chk(n_wr - w0, 0, "R9 no write from ignored request");
        chk(busy, 1'b0, "R9 idle after access");
        chk(rdata, e, "R10 rdata held while idle");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_one_word();
        t_two_words();
        t_four_words();
        t_stores();
        t_fault();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule